// File: doc/BRIEF.md
# Fuse Array Byte Read Sequencer

This block turns a single request (a start byte offset and a byte count) into the full pin sequence that a one-time-programmable fuse macro needs for a read. It leaves standby by raising load with program-enable-bar still high, which pulls chip-select-bar low. It then walks through the requested bytes. For each byte it drives the address, pulses strobe and samples the macro's 8-bit data output, and at the end it parks the macro back in standby. Every settle gap lasts at least one microsecond. The gap length comes from a clock-frequency parameter and is rounded up to whole cycles.

Bytes leave the block on a valid/ready stream. A consumer that holds ready low stretches the strobe-high phase, so no sample is lost. Write requests are acknowledged and discarded, because the array is read-only through this path.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset, and whenever no session is running, the control word is 0x009: chip-select-bar (bit 0) = 1, strobe (bit 1) = 0, load (bit 2) = 0, program-enable-bar (bit 3) = 1, address field (bits 15:6) = 0. `busy_o` = 0 and `byte_valid_o` = 0.
- R2: A start with a non-zero count has the following effect from the next cycle on. `busy_o` goes high and the control word reads 0x00C (load and program-enable-bar high, chip-select-bar low) for W cycles, where W = ceil(CLK_KHZ/1000).
- R3: For each byte, the offset is driven on bits 15:6 with load and program-enable-bar high, and it stays there for W cycles before strobe rises. The address does not change on the cycle strobe rises.
- R4: Strobe (bit 1) stays high for W cycles. In the last of those cycles the macro output is captured. The captured byte is then shown on `byte_data_o` with `byte_valid_o` high, while strobe is still high.
- R5: While `byte_valid_o` is high and `byte_ready_i` is low, strobe stays high and both `byte_valid_o` and `byte_data_o` hold their values.
- R6: After a valid/ready handshake, strobe falls and the same address is held for W cycles. The next byte then uses the offset plus one.
- R7: After the last requested byte and its W-cycle recovery, the pins return to 0x009 and `busy_o` falls. Exactly the requested number of bytes are delivered.
- R8: Offsets are 10 bits wide and wrap from 1023 to 0.
- R9: A start pulse while `busy_o` is high is ignored. The running session keeps its offset and count.
- R10: A start with a count of zero leaves the block in standby. `busy_o` stays low and strobe never rises.
- R11: A write request raises `wr_ack_o` on the next cycle and changes neither the pins nor `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a read session (taken only when idle) |
| start_off_i | input | 10 | First byte offset |
| start_cnt_i | input | 11 | Number of bytes to read |
| wr_req_i | input | 1 | Write request (discarded) |
| wr_ack_o | output | 1 | Write request acknowledge, one cycle later |
| busy_o | output | 1 | Session in progress |
| fuse_ctrl_o | output | 16 | Macro control word: pins in bits 3:0, address in bits 15:6 |
| fuse_dout_i | input | 8 | Macro data output |
| byte_data_o | output | 8 | Read byte |
| byte_valid_o | output | 1 | Read byte valid |
| byte_ready_i | input | 1 | Consumer ready |

## Verification
The phase state, the settle timer and the offset counter are all visible on `fuse_ctrl_o` in every cycle. A wrong phase or a miscounted gap therefore shows up as a control-word mismatch in the first cycle it occurs. A wrong offset shows up on the address field, and one cycle later on the data returned through the stream. A wrong remaining count shows up only at the end of a session, when `busy_o` falls one byte early or late. A stall fault shows up when strobe drops or the data changes while ready is held low.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;
  localparam int CSB_BIT   = 0;
  localparam int STRB_BIT  = 1;
  localparam int LOAD_BIT  = 2;
  localparam int PGENB_BIT = 3;
  localparam int ADDR_LSB  = 6;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PWRUP = 3'd1,
    PH_ADDR  = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;
endpackage

// File: rtl/fuse_us_timer.sv
module fuse_us_timer #(
  parameter int CLK_KHZ = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int RAW_CYC  = (CLK_KHZ + 999) / 1000;
  localparam int WAIT_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;
  localparam int CW       = $clog2(WAIT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= CW'(WAIT_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CW'(1));

  AST_TMR_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && WAIT_CYC > 1) |=> !done_o); // R2
endmodule

// File: rtl/fuse_addr_ctr.sv
module fuse_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] off_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] off_q;
  logic [CNT_W-1:0]  rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      off_q <= off_i;
      rem_q <= cnt_i;
    end else if (step_i) begin
      off_q <= off_q + 1'b1;   // wraps within the address width
      rem_q <= rem_q - 1'b1;
    end
  end

  assign off_o  = off_q;
  assign last_o = (rem_q == CNT_W'(1));

  AST_OFF_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && off_q == '1) |=> (off_q == '0)); // R8
endmodule

// File: rtl/fuse_pin_enc.sv
module fuse_pin_enc
  import fuse_rd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = ADDR_LSB + ADDR_W
) (
  input  phase_e            phase_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (phase_i)
      PH_IDLE: begin
        ctrl_o[CSB_BIT]   = 1'b1;
        ctrl_o[PGENB_BIT] = 1'b1;
      end
      PH_PWRUP: begin
        ctrl_o[LOAD_BIT]  = 1'b1;
        ctrl_o[PGENB_BIT] = 1'b1;
      end
      PH_ADDR, PH_RECOV: begin
        ctrl_o[LOAD_BIT]  = 1'b1;
        ctrl_o[PGENB_BIT] = 1'b1;
        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
      end
      PH_STRB, PH_HOLD: begin
        ctrl_o[LOAD_BIT]  = 1'b1;
        ctrl_o[PGENB_BIT] = 1'b1;
        ctrl_o[STRB_BIT]  = 1'b1;
        ctrl_o[ADDR_LSB +: ADDR_W] = addr_i;
      end
      default: begin
        ctrl_o[CSB_BIT]   = 1'b1;
        ctrl_o[PGENB_BIT] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 11,
  parameter int DATA_W  = 8,
  localparam int CTRL_W = ADDR_LSB + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_off_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic              wr_req_i,
  output logic              wr_ack_o,
  output logic              busy_o,
  output logic [CTRL_W-1:0] fuse_ctrl_o,
  input  logic [DATA_W-1:0] fuse_dout_i,
  output logic [DATA_W-1:0] byte_data_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i
);
  localparam logic [CTRL_W-1:0] STBY_WORD =
    CTRL_W'((1 << CSB_BIT) | (1 << PGENB_BIT));

  phase_e            phase_q, phase_d;
  logic              tmr_done;
  logic              go;
  logic              step;
  logic              last;
  logic [ADDR_W-1:0] cur_off;
  logic [DATA_W-1:0] data_q;
  logic              ack_q;

  assign go   = (phase_q == PH_IDLE) && start_i && (start_cnt_i != '0);
  assign step = (phase_q == PH_RECOV) && tmr_done;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (go)           phase_d = PH_PWRUP;
      PH_PWRUP: if (tmr_done)     phase_d = PH_ADDR;
      PH_ADDR:  if (tmr_done)     phase_d = PH_STRB;
      PH_STRB:  if (tmr_done)     phase_d = PH_HOLD;
      PH_HOLD:  if (byte_ready_i) phase_d = PH_RECOV;
      PH_RECOV: if (tmr_done)     phase_d = last ? PH_IDLE : PH_ADDR;
      default:                    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              data_q <= '0;
    else if (phase_q == PH_STRB && tmr_done)  data_q <= fuse_dout_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= wr_req_i;
  end

  fuse_us_timer #(.CLK_KHZ(CLK_KHZ)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase_d != phase_q),
    .done_o (tmr_done)
  );

  fuse_addr_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .off_i  (start_off_i),
    .cnt_i  (start_cnt_i),
    .step_i (step),
    .off_o  (cur_off),
    .last_o (last)
  );

  fuse_pin_enc #(.ADDR_W(ADDR_W)) u_enc (
    .phase_i (phase_q),
    .addr_i  (cur_off),
    .ctrl_o  (fuse_ctrl_o)
  );

  assign busy_o       = (phase_q != PH_IDLE);
  assign byte_valid_o = (phase_q == PH_HOLD);
  assign byte_data_o  = data_q;
  assign wr_ack_o     = ack_q;

  AST_STBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fuse_ctrl_o == STBY_WORD && !byte_valid_o)); // R1
  AST_STRB_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_ctrl_o[STRB_BIT] |-> (fuse_ctrl_o[LOAD_BIT] && !fuse_ctrl_o[CSB_BIT])); // R4
  AST_ADDR_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fuse_ctrl_o[STRB_BIT]) |-> $stable(fuse_ctrl_o[CTRL_W-1:ADDR_LSB])); // R3
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=>
      (byte_valid_o && $stable(byte_data_o) && fuse_ctrl_o[STRB_BIT])); // R5
  AST_BUSY_START_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !step) |=> $stable(cur_off)); // R9
  AST_ZERO_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && start_cnt_i == '0) |=> !busy_o); // R10
  AST_WR_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !busy_o && !start_i) |=> (!busy_o && wr_ack_o)); // R11
endmodule

// File: tb/fuse_rd_seq_bench.sv
module fuse_rd_seq_bench;
  localparam int W = 50; // 50 MHz clock, one microsecond per gap

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  s_off = '0;
  logic [10:0] s_cnt = '0;
  logic        wr_req = 1'b0;
  logic        wr_ack;
  logic        busy;
  logic [15:0] ctrl;
  logic [7:0]  dout;
  logic [7:0]  bdata;
  logic        bvalid;
  logic        rdy = 1'b1;
  int          rdy_mode = 0;
  logic [7:0]  lfsr = 8'h1d;

  int n_cmp = 0, n_bad = 0, cyc = 0, n_bytes = 0;
  int addr_seen[$];

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [9:0] a);
    return a[7:0] ^ {a[9:8], 6'b0} ^ 8'hA5;
  endfunction

  assign dout = ctrl[1] ? pat(ctrl[15:6]) : 8'h00;

  fuse_rd_seq #(.CLK_KHZ(50000)) u_fuse_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_off_i(s_off),
    .start_cnt_i(s_cnt), .wr_req_i(wr_req), .wr_ack_o(wr_ack), .busy_o(busy),
    .fuse_ctrl_o(ctrl), .fuse_dout_i(dout), .byte_data_o(bdata),
    .byte_valid_o(bvalid), .byte_ready_i(rdy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle,1 power-up,2 address,3 strobe,4 hold,5 recovery
  int m_ph = 0, m_t = 0, m_off = 0, m_rem = 0;
  logic [7:0] m_data = '0;
  logic m_ack = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_off = 0; m_rem = 0; m_data = '0; m_ack = 1'b0;
    end else begin
      if (bvalid && rdy) n_bytes++;
      m_ack = wr_req;
      case (m_ph)
        0: if (start && s_cnt != 0) begin
             m_off = int'(s_off); m_rem = int'(s_cnt); m_ph = 1; m_t = W;
           end
        1: if (m_t == 1) begin m_ph = 2; m_t = W; end else m_t--;
        2: if (m_t == 1) begin m_ph = 3; m_t = W; end else m_t--;
        3: if (m_t == 1) begin m_ph = 4; m_data = pat(10'(m_off)); end else m_t--;
        4: if (rdy) begin m_ph = 5; m_t = W; end
        5: if (m_t == 1) begin
             m_rem--; m_off = (m_off + 1) % 1024;
             if (m_rem == 0) m_ph = 0; else begin m_ph = 2; m_t = W; end
           end else m_t--;
        default: m_ph = 0;
      endcase
    end
  end

  function automatic logic [15:0] exp_ctrl();
    case (m_ph)
      0: return 16'h0009;
      1: return 16'h000C;
      2, 5: return 16'h000C | 16'(m_off << 6);
      default: return 16'h000E | 16'(m_off << 6);
    endcase
  endfunction

  function automatic string ph_tag();
    case (m_ph)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  logic prev_strb = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk({ph_tag(), " ctrl"}, 32'(ctrl), 32'(exp_ctrl()));
      chk({ph_tag(), " busy"}, 32'(busy), 32'(m_ph != 0));
      chk({ph_tag(), " valid"}, 32'(bvalid), 32'(m_ph == 4));
      chk("R11 wr_ack", 32'(wr_ack), 32'(m_ack));
      if (m_ph == 4) chk("R4 data", 32'(bdata), 32'(m_data));
      if (ctrl[1] && !prev_strb) addr_seen.push_back(int'(ctrl[15:6]));
      prev_strb = ctrl[1];
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0: rdy <= 1'b1;
      1: rdy <= lfsr[0];
      default: rdy <= 1'b0;
    endcase
  end

  task automatic do_start(input int off, input int cnt);
    @(negedge clk);
    start = 1'b1; s_off = 10'(off); s_cnt = 11'(cnt);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ctrl", 32'(ctrl), 32'h0009);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset valid", 32'(bvalid), 0);

    // Plain three-byte read
    n_bytes = 0; addr_seen.delete();
    do_start(5, 3);
    chk("R2 busy after start", 32'(busy), 1);
    chk("R2 pwrup word", 32'(ctrl), 32'h000C);
    wait_idle();
    chk("R7 byte count", 32'(n_bytes), 3);
    chk("R7 standby", 32'(ctrl), 32'h0009);
    chk("R6 offsets", 32'(addr_seen.size() == 3 && addr_seen[0] == 5 && addr_seen[2] == 7), 1);

    // Write request in idle
    @(negedge clk); wr_req = 1'b1;
    @(negedge clk); wr_req = 1'b0;
    chk("R11 ack", 32'(wr_ack), 1);
    chk("R11 no session", 32'(busy), 0);
    chk("R11 pins", 32'(ctrl), 32'h0009);

    // Wrapping read with random ready, a stray start and a write while busy
    n_bytes = 0; addr_seen.delete(); rdy_mode = 1;
    do_start(1022, 4);
    repeat (120) @(negedge clk);
    do_start(100, 2);
    wr_req = 1'b1; @(negedge clk); wr_req = 1'b0;
    wait_idle();
    rdy_mode = 0;
    chk("R9 byte count", 32'(n_bytes), 4);
    chk("R8 wrap list", 32'(addr_seen.size() == 4 && addr_seen[0] == 1022 &&
        addr_seen[1] == 1023 && addr_seen[2] == 0 && addr_seen[3] == 1), 1);

    // Zero count
    n_bytes = 0; addr_seen.delete();
    do_start(40, 0);
    repeat (5) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 no strobe", 32'(addr_seen.size()), 0);
    chk("R10 pins", 32'(ctrl), 32'h0009);

    // Long stall with ready low
    n_bytes = 0; rdy_mode = 2;
    do_start(300, 1);
    while (!bvalid) @(negedge clk);
    repeat (200) @(negedge clk);
    chk("R5 still valid", 32'(bvalid), 1);
    chk("R5 strobe high", 32'(ctrl[1]), 1);
    chk("R5 data", 32'(bdata), 32'(pat(10'd300)));
    rdy_mode = 0;
    wait_idle();
    chk("R7 single byte", 32'(n_bytes), 1);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule